// File: doc/BRIEF.md
# Butterfly Bit Permutation Unit

A combinational permutation datapath for a scalar integer pipeline. It takes one operand and a small control amount and produces a rearranged copy of the operand. Four operations share one block:

- generalized bit reversal, which swaps blocks of bits;
- generalized OR-combine, which ORs each block with its swapped neighbour;
- perfect shuffle, which interleaves bits;
- the inverse shuffle.

Each bit of the control amount switches one butterfly stage on or off independently. One setting of the amount therefore covers a whole family of operations, such as bit reversal, byte swap, nibble swap or zip and unzip.

A half-width mode treats the operand as two independent words, each half of the full width. In this mode the stage that would move bits between the two halves is disabled. The control amount may come from a register or from an immediate field; the block does not distinguish the two. The result is available in the same cycle, so the unit is normally placed in front of a pipeline register in the execute stage.

Top module: `bperm_unit`

## Requirements
- R1: With op_i = 2'b00 (reverse) and half_i = 0, bit i of result_o equals bit (i XOR amt_i) of opnd_i.
- R2: With op_i = 2'b01 (OR-combine) and half_i = 0, bit i of result_o is the OR of every opnd_i bit j for which (i XOR j) has no bit set outside amt_i. The result therefore always contains every set bit of the operand.
- R3: With op_i = 2'b10 (shuffle), each stage k from 0 to LOG2(XLEN)-2 is enabled by amt_i[k]. The enabled stages run in descending k. Stage k moves the bit at index p to the index obtained by swapping bits k and k+1 of p. amt_i[LOG2(XLEN)-1] has no effect on the shuffle.
- R4: With op_i = 2'b11 (unshuffle), the same stages run in ascending k. Unshuffle with amount a exactly undoes shuffle with amount a.
- R5: With half_i = 1, each half-width word is processed on its own and no bit crosses between the halves. amt_i[LOG2(XLEN)-1] is ignored by reverse and OR-combine. amt_i[LOG2(XLEN)-2] is ignored by the two shuffles.
- R6: With amt_i = 0, result_o equals opnd_i for every operation and either width mode.
- R7: At XLEN = 64 in full-width mode:
  - reverse with amount 63 reverses all 64 bits;
  - reverse with amount 56 reverses the byte order;
  - OR-combine with amount 7 turns every byte that has any bit set into 0xFF and leaves zero bytes as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | XLEN | Operand to permute |
| amt_i | input | LOG2(XLEN) | Stage enable amount, from a register or an immediate |
| op_i | input | 2 | Operation: 00 reverse, 01 OR-combine, 10 shuffle, 11 unshuffle |
| half_i | input | 1 | 1 processes the two half-width words independently |
| result_o | output | XLEN | Permuted result, combinational |

## Verification
The bound checker watches every input change. It checks that reverse and both shuffles keep the number of set bits, both over the whole word and separately in each half in half-width mode. It checks that OR-combine never clears an operand bit, and that a zero amount returns the operand unchanged. Those checks cannot show that a bit lands in exactly the right position, that the shuffle stages run in the right order, or that a control bit is ignored when it should be. The bench covers these by comparing every amount, in both width modes, against index-arithmetic models. It also feeds each shuffle result back through the unshuffle, and checks the named bit-reverse, byte-reverse and byte OR-combine cases.

// File: rtl/bperm_pkg.sv
`timescale 1ns/1ps
package bperm_pkg;
   typedef enum logic [1:0] {
      BP_REV    = 2'b00,
      BP_ORC    = 2'b01,
      BP_SHUF   = 2'b10,
      BP_UNSHUF = 2'b11
   } bperm_op_e;
endpackage

// File: rtl/bperm_swap_net.sv
`timescale 1ns/1ps
// Reverse / OR-combine network: stage k swaps neighbouring 2^k-bit blocks.
module bperm_swap_net #(
   parameter int XLEN = 64,
   parameter int LOGX = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] x_i,
   input  logic [LOGX-1:0] amt_i,
   input  logic            or_mode_i,
   input  logic            half_i,
   output logic [XLEN-1:0] y_o
);
   // Bits whose index has bit k clear form the lower member of each block pair.
   function automatic logic [XLEN-1:0] low_blocks(input int k);
      logic [XLEN-1:0] m;
      for (int i = 0; i < XLEN; i++) m[i] = ((i >> k) & 1) == 0;
      return m;
   endfunction

   logic [XLEN-1:0] stage_q [0:LOGX];
   assign stage_q[0] = x_i;

   for (genvar k = 0; k < LOGX; k++) begin : g_stage
      localparam int SH = 1 << k;
      localparam logic [XLEN-1:0] LOWM = low_blocks(k);
      localparam bit CROSS = (k == LOGX - 1);
      logic [XLEN-1:0] swapped;
      logic            en;
      assign swapped = ((stage_q[k] & LOWM) << SH) | ((stage_q[k] & ~LOWM) >> SH);
      if (CROSS) begin : g_top
         assign en = amt_i[k] & ~half_i;
      end else begin : g_inner
         assign en = amt_i[k];
      end
      always_comb begin
         if (!en)            stage_q[k+1] = stage_q[k];
         else if (or_mode_i) stage_q[k+1] = stage_q[k] | swapped;
         else                stage_q[k+1] = swapped;
      end
   end

   assign y_o = stage_q[LOGX];
endmodule

// File: rtl/bperm_shuf_net.sv
`timescale 1ns/1ps
// Shuffle network: stage k swaps index bits k and k+1; order picked by direction.
module bperm_shuf_net #(
   parameter int XLEN = 64,
   parameter int LOGX = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] x_i,
   input  logic [LOGX-1:0] amt_i,
   input  logic            inverse_i,
   input  logic            half_i,
   output logic [XLEN-1:0] y_o
);
   localparam int NST = LOGX - 1;

   // Destination lanes for bits moving up (hi) or down (lo) in stage k.
   function automatic logic [XLEN-1:0] lane_mask(input int k, input bit hi);
      logic [XLEN-1:0] m;
      for (int i = 0; i < XLEN; i++)
         m[i] = hi ? ((((i >> (k + 1)) & 1) == 1) && (((i >> k) & 1) == 0))
                   : ((((i >> (k + 1)) & 1) == 0) && (((i >> k) & 1) == 1));
      return m;
   endfunction

   function automatic logic [XLEN-1:0] run_stage(input logic [XLEN-1:0] v, input int k);
      logic [XLEN-1:0] ml, mr;
      ml = lane_mask(k, 1'b1);
      mr = lane_mask(k, 1'b0);
      return (v & ~(ml | mr)) | ((v << (1 << k)) & ml) | ((v >> (1 << k)) & mr);
   endfunction

   logic [XLEN-1:0] stage_q [0:NST];
   assign stage_q[0] = x_i;

   for (genvar s = 0; s < NST; s++) begin : g_stage
      localparam int KF = NST - 1 - s;   // forward: widest stage first
      localparam int KR = s;             // inverse: narrowest stage first
      logic [XLEN-1:0] fwd_v, inv_v;
      logic            en_f, en_r;
      assign fwd_v = run_stage(stage_q[s], KF);
      assign inv_v = run_stage(stage_q[s], KR);
      assign en_f  = amt_i[KF] & ~(half_i & (KF == NST - 1));
      assign en_r  = amt_i[KR] & ~(half_i & (KR == NST - 1));
      always_comb begin
         if (inverse_i) stage_q[s+1] = en_r ? inv_v : stage_q[s];
         else           stage_q[s+1] = en_f ? fwd_v : stage_q[s];
      end
   end

   assign y_o = stage_q[NST];
endmodule

// File: rtl/bperm_unit.sv
`timescale 1ns/1ps
module bperm_unit #(
   parameter int XLEN = 64,
   parameter int LOGX = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] opnd_i,
   input  logic [LOGX-1:0] amt_i,
   input  logic [1:0]      op_i,
   input  logic            half_i,
   output logic [XLEN-1:0] result_o
);
   import bperm_pkg::*;

   if ((1 << LOGX) != XLEN || XLEN < 8) begin : g_bad_width
      $error("bperm_unit: XLEN must be a power of two of at least 8");
   end

   bperm_op_e       op;
   logic [XLEN-1:0] swap_y, shuf_y;

   assign op = bperm_op_e'(op_i);

   bperm_swap_net #(.XLEN(XLEN), .LOGX(LOGX)) u_swap (
      .x_i       (opnd_i),
      .amt_i     (amt_i),
      .or_mode_i (op == BP_ORC),
      .half_i    (half_i),
      .y_o       (swap_y)
   );

   bperm_shuf_net #(.XLEN(XLEN), .LOGX(LOGX)) u_shuf (
      .x_i       (opnd_i),
      .amt_i     (amt_i),
      .inverse_i (op == BP_UNSHUF),
      .half_i    (half_i),
      .y_o       (shuf_y)
   );

   always_comb begin
      unique case (op)
         BP_REV, BP_ORC:    result_o = swap_y;
         BP_SHUF, BP_UNSHUF: result_o = shuf_y;
         default:           result_o = swap_y;
      endcase
   end
endmodule

// File: rtl/bperm_unit_chk.sv
`timescale 1ns/1ps
module bperm_unit_chk #(
   parameter int XLEN = 64,
   parameter int LOGX = $clog2(XLEN)
) (
   input logic [XLEN-1:0] opnd_i,
   input logic [LOGX-1:0] amt_i,
   input logic [1:0]      op_i,
   input logic            half_i,
   input logic [XLEN-1:0] result_o
);
   localparam int HW = XLEN / 2;

   always_comb begin
      if (!$isunknown({opnd_i, amt_i, op_i, half_i})) begin
         assert_zero_amount_identity_R6: assert (amt_i != '0 || result_o == opnd_i);
         assert_orc_keeps_bits_R2: assert (op_i != 2'b01 || (result_o & opnd_i) == opnd_i);
         assert_rev_popcount_R1: assert (op_i != 2'b00 ||
            $countones(result_o) == $countones(opnd_i));
         assert_shuf_popcount_R3: assert (op_i != 2'b10 ||
            $countones(result_o) == $countones(opnd_i));
         assert_unshuf_popcount_R4: assert (op_i != 2'b11 ||
            $countones(result_o) == $countones(opnd_i));
         assert_half_isolation_R5: assert (!half_i || op_i == 2'b01 ||
            ($countones(result_o[HW-1:0]) == $countones(opnd_i[HW-1:0]) &&
             $countones(result_o[XLEN-1:HW]) == $countones(opnd_i[XLEN-1:HW])));
      end
   end
endmodule

bind bperm_unit bperm_unit_chk #(.XLEN(XLEN), .LOGX(LOGX)) u_chk (.*);

// File: tb/bperm_unit_tb.sv
`timescale 1ns/1ps
module bperm_unit_tb;
   logic        clk = 1'b0;
   logic [63:0] opnd;
   logic [5:0]  amt;
   logic [1:0]  op;
   logic        half;
   logic [63:0] result;
   int          checks = 0;
   int          fails  = 0;
   bit          done   = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   bperm_unit u_dut (.opnd_i(opnd), .amt_i(amt), .op_i(op), .half_i(half), .result_o(result));

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%016h expected=%016h (op=%0d amt=%0d half=%0d)",
                  req, got, exp, op, amt, half);
      end
   endtask

   task automatic apply(input logic [63:0] d, input logic [5:0] a, input logic [1:0] o,
                        input logic h);
      @(posedge clk);
      opnd = d; amt = a; op = o; half = h;
      @(negedge clk);
   endtask

   function automatic logic [63:0] ref_rev(input logic [63:0] x, input logic [5:0] a,
                                           input logic h);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) begin
         int j = h ? ((i & 32) | ((i ^ a) & 31)) : (i ^ a);
         r[i] = x[j];
      end
      return r;
   endfunction

   function automatic logic [63:0] ref_orc(input logic [63:0] x, input logic [5:0] a,
                                           input logic h);
      logic [63:0] r = '0;
      int free = h ? (a & 31) : a;
      for (int i = 0; i < 64; i++)
         for (int j = 0; j < 64; j++)
            if ((((i ^ j) & ~free) & 63) == 0) r[i] = r[i] | x[j];
      return r;
   endfunction

   function automatic logic [63:0] ref_shuf(input logic [63:0] x, input logic [5:0] a,
                                            input logic inv, input logic h);
      logic [63:0] r = '0;
      for (int p = 0; p < 64; p++) begin
         int idx = p;
         for (int s = 0; s < 5; s++) begin
            int k = inv ? s : 4 - s;
            if (a[k] && !(h && k == 4)) begin
               int b0 = (idx >> k) & 1;
               int b1 = (idx >> (k + 1)) & 1;
               if (b0 != b1) idx = idx ^ (3 << k);
            end
         end
         r[idx] = x[p];
      end
      return r;
   endfunction

   initial begin
      logic [63:0] pats [6];
      pats[0] = 64'h0123_4567_89AB_CDEF;
      pats[1] = 64'h8000_0000_0000_0001;
      pats[2] = 64'h0000_0000_FFFF_FFFF;
      pats[3] = 64'hF0E1_D2C3_B4A5_9687;
      pats[4] = 64'h0000_0000_0001_0000;
      pats[5] = 64'hAAAA_5555_CCCC_3333;
      opnd = '0; amt = '0; op = '0; half = 1'b0;
      @(negedge clk);
      check("R6 initial zero operand", result, 64'h0);

      for (int p = 0; p < 6; p++)
         for (int h = 0; h < 2; h++)
            for (int o = 0; o < 4; o++)
               for (int a = 0; a < 64; a++) begin
                  logic [63:0] e, fwd;
                  apply(pats[p], 6'(a), 2'(o), 1'(h));
                  case (o)
                     0: e = ref_rev(pats[p], 6'(a), 1'(h));
                     1: e = ref_orc(pats[p], 6'(a), 1'(h));
                     2: e = ref_shuf(pats[p], 6'(a), 1'b0, 1'(h));
                     default: e = ref_shuf(pats[p], 6'(a), 1'b1, 1'(h));
                  endcase
                  if (h == 1)      check("R5 half-width word", result, e);
                  else if (o == 0) check("R1 reverse", result, e);
                  else if (o == 1) check("R2 or-combine", result, e);
                  else if (o == 2) check("R3 shuffle", result, e);
                  else             check("R4 unshuffle", result, e);
                  if (a == 0) check("R6 zero amount identity", result, pats[p]);
                  if (o == 2) begin
                     fwd = result;
                     apply(fwd, 6'(a), 2'b11, 1'(h));
                     check("R4 unshuffle undoes shuffle", result, pats[p]);
                  end
               end

      apply(64'h0000_0000_0000_0001, 6'd63, 2'b00, 1'b0);
      check("R7 full bit reverse", result, 64'h8000_0000_0000_0000);
      apply(64'h0123_4567_89AB_CDEF, 6'd63, 2'b00, 1'b0);
      check("R7 full bit reverse pattern", result, 64'hF7B3_D591_E6A2_C480);
      apply(64'h0123_4567_89AB_CDEF, 6'd56, 2'b00, 1'b0);
      check("R7 byte reverse", result, 64'hEFCD_AB89_6745_2301);
      apply(64'h0001_0080_0000_1000, 6'd7, 2'b01, 1'b0);
      check("R7 byte or-combine", result, 64'h00FF_00FF_0000_FF00);
      apply(64'h0123_4567_89AB_CDEF, 6'd32, 2'b00, 1'b1);
      check("R5 top amount bit ignored in half mode", result, 64'h0123_4567_89AB_CDEF);
      apply(64'h0123_4567_89AB_CDEF, 6'd16, 2'b10, 1'b1);
      check("R5 widest shuffle stage ignored in half mode", result, 64'h0123_4567_89AB_CDEF);
      apply(64'h0123_4567_89AB_CDEF, 6'd32, 2'b10, 1'b0);
      check("R3 top amount bit ignored by shuffle", result, 64'h0123_4567_89AB_CDEF);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule